// File: doc/BRIEF.md
# RV32C Compressed Instruction Expander

This block sits between instruction fetch and decode. It takes one 32-bit fetched word and looks at its two lowest bits. When they are not both set, the low halfword is a compressed instruction. The block rewrites it into the equivalent full-width base-ISA instruction, so that the decoder downstream only ever sees 32-bit encodings. When the two lowest bits are both set, the word is already a full instruction and goes through untouched.

The block is purely combinational. Besides the rewritten word it produces two flags. One marks that the input was compressed, so the fetch logic can advance the program counter by two instead of four. The other marks a compressed encoding that is reserved or not supported on a 32-bit integer core, and the decode stage turns that into an illegal-instruction exception. Floating-point compressed loads and stores count as unsupported.

The decoding follows the split rules of the compressed extension exactly. In the register-move and register-add groups, the second source field decides the instruction before the destination field does. The HINT code points are rewritten into the matching base-ISA hints, so they behave as no-ops that write x0 or leave state unchanged. They are not flagged.

Top module: `rvc_expander`

## Requirements
- R1: When word bits [1:0] are 2'b11, the output word equals the input word, the compressed flag is 0 and the illegal flag is 0.
- R2: When bits [1:0] are not 2'b11, the compressed flag is 1 and bits [31:16] of the input have no effect on the result. A legal expansion has output bits [1:0] = 2'b11. Whenever the illegal flag is 1, the output word equals the input word.
- R3: Quadrant 0 (bits [1:0]=00, funct3 in bits [15:13]) handles three forms. funct3=000 expands to addi rd'(x8+bits[4:2]), x2, imm, with the scaled immediate taken from bits [12:5]. funct3=010 becomes lw and funct3=110 becomes sw, using rs1'=x8+bits[9:7]. An all-zero halfword, and funct3=000 with bits [12:5]=0, are illegal.
- R4: Quadrant 0 funct3 values 001, 011, 100, 101 and 111, and quadrant 2 funct3 values 001, 011, 101 and 111, are illegal. These cover the floating-point forms and the reserved slot.
- R5: In quadrant 1, funct3=000 expands to addi rd,rd,simm and funct3=010 to addi rd,x0,simm. rd is bits [11:7] and simm is bits {12,6:2} sign-extended. funct3=001 becomes jal x1 and funct3=101 becomes jal x0, with the scrambled 12-bit offset restored. rd=x0 and zero-immediate forms are legal hints.
- R6: In quadrant 1 funct3=011, rd=x2 selects addi x2,x2,imm, with the immediate scaled by 16 from bits {12,4:3,5,2,6}. Any other rd selects lui rd with bits {12,6:2} sign-extended as the upper immediate. A zero 6-bit immediate is illegal in both forms. rd=x0 for lui is a legal hint.
- R7: The shift forms are srli (quadrant 1, funct3=100, bits[11:10]=00), srai (bits[11:10]=01) and slli (quadrant 2, funct3=000). They expand to the base shift-immediate forms with shamt in bits [6:2]. Bit 12 set is illegal. shamt=0 and slli with rd=x0 are legal hints.
- R8: In quadrant 1 funct3=100, bits[11:10]=10 expands to andi. bits[11:10]=11 with bit 12 clear expands to sub/xor/or/and for bits[6:5]=00/01/10/11, with rd'=x8+bits[9:7] and rs2'=x8+bits[4:2]. bits[11:10]=11 with bit 12 set is illegal.
- R9: Quadrant 1 funct3=110/111 expands to beq/bne rs1', x0 with the scrambled 9-bit offset restored.
- R10: In quadrant 2 with bits[15:12]=1000, rs2 (bits [6:2]) is tested first. Nonzero rs2 gives add rd,x0,rs2, and rd=x0 there is a legal hint. Zero rs2 gives jalr x0,0(rs1), and rs1=x0 there is illegal.
- R11: In quadrant 2 with bits[15:12]=1001, rs2 is tested first. Nonzero rs2 gives add rd,rd,rs2, and rd=x0 is a legal hint. Zero rs2 gives jalr x1,0(rs1), or ebreak (32'h00100073) when rs1 is also x0.
- R12: Quadrant 2 funct3=010 expands to lw rd, off(x2), with the offset scaled by 4 from bits {3:2,12,6:4}. rd=x0 is illegal. funct3=110 expands to sw rs2, off(x2), with the offset from bits {8:7,12:9}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Fetched word; the low halfword holds a compressed instruction when bits [1:0] are not 11 |
| instr_o | output | 32 | Full-width instruction, or the raw input word when illegal |
| is_compressed_o | output | 1 | High when the input was a compressed instruction |
| illegal_o | output | 1 | High for a reserved or unsupported compressed encoding |

## Verification
Some behaviours are invariants that hold on any input, and the assertions check these on every evaluation. They cover:
- the pass-through of full-width words,
- the raw word returned when the illegal flag is set,
- full-width opcode bits on every legal expansion,
- the zero-immediate and shift-amount reserved cases,
- the jump-register reserved case and the breakpoint mapping.

Whether each immediate is reassembled bit for bit in the right order, and whether the rs2-before-rd precedence picks the right base instruction, can only be shown by the bench's scenarios. These are a table of hand-encoded vectors, a sweep over every rd/rs2 pair in the two register groups of quadrant 2, and a sweep over all 65536 halfwords.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

    localparam int ILEN  = 32;
    localparam int CLEN  = 16;
    localparam int REG_W = 5;
    localparam int OPC_W = 7;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'h13;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
    localparam logic [OPC_W-1:0] OPC_OP     = 7'h33;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'h37;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'h67;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'h6f;

    localparam logic [ILEN-1:0] BREAK_WORD = 32'h0010_0073;

    typedef enum logic [1:0] {
        QUAD0     = 2'b00,
        QUAD1     = 2'b01,
        QUAD2     = 2'b10,
        QUAD_FULL = 2'b11
    } quad_e;

    typedef struct packed {
        logic [ILEN-1:0] word;
        logic            illegal;
    } xlat_t;

    // three-bit register field maps onto x8..x15
    function automatic logic [REG_W-1:0] creg(input logic [2:0] r);
        return {2'b01, r};
    endfunction

    function automatic logic [ILEN-1:0] form_i(input logic [11:0] imm,
                                               input logic [REG_W-1:0] rs1,
                                               input logic [2:0] f3,
                                               input logic [REG_W-1:0] rd,
                                               input logic [OPC_W-1:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [ILEN-1:0] form_r(input logic [6:0] f7,
                                               input logic [REG_W-1:0] rs2,
                                               input logic [REG_W-1:0] rs1,
                                               input logic [2:0] f3,
                                               input logic [REG_W-1:0] rd);
        return {f7, rs2, rs1, f3, rd, OPC_OP};
    endfunction

    function automatic logic [ILEN-1:0] form_s(input logic [11:0] imm,
                                               input logic [REG_W-1:0] rs2,
                                               input logic [REG_W-1:0] rs1);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OPC_STORE};
    endfunction

endpackage

// File: rtl/rvc_exp_q0.sv
module rvc_exp_q0
    import rvc_pkg::*;
(
    input  logic [15:2] c_i,
    output xlat_t       res_o
);

    logic [9:0]  wide_imm;
    logic [11:0] word_off;

    assign wide_imm = {c_i[10:7], c_i[12:11], c_i[5], c_i[6], 2'b00};
    assign word_off = {5'b0, c_i[5], c_i[12:10], c_i[6], 2'b00};

    always_comb begin
        res_o.word    = '0;
        res_o.illegal = 1'b0;
        case (c_i[15:13])
            3'b000: begin
                res_o.word    = form_i({2'b00, wide_imm}, 5'd2, 3'b000,
                                       creg(c_i[4:2]), OPC_OPIMM);
                res_o.illegal = (wide_imm == '0);
            end
            3'b010: begin
                res_o.word = form_i(word_off, creg(c_i[9:7]), 3'b010,
                                    creg(c_i[4:2]), OPC_LOAD);
            end
            3'b110: begin
                res_o.word = form_s(word_off, creg(c_i[4:2]), creg(c_i[9:7]));
            end
            default: res_o.illegal = 1'b1;
        endcase
    end

    // R3
    always_comb begin
        if (c_i[15:13] == 3'b000 && c_i[12:5] == 8'h00)
            addi4spn_zero_chk: assert (res_o.illegal)
                else $error("zero stack-offset add not flagged");
    end

endmodule

// File: rtl/rvc_exp_q1.sv
module rvc_exp_q1
    import rvc_pkg::*;
(
    input  logic [15:2] c_i,
    output xlat_t       res_o
);

    logic [11:0] simm;
    logic [11:0] sp_imm;
    logic [19:0] up_imm;
    logic [4:0]  rd_full;
    logic [4:0]  rd_p;
    logic [4:0]  rs2_p;
    logic        imm_zero;

    assign simm     = {{6{c_i[12]}}, c_i[12], c_i[6:2]};
    assign sp_imm   = {{3{c_i[12]}}, c_i[4:3], c_i[5], c_i[2], c_i[6], 4'b0000};
    assign up_imm   = {{14{c_i[12]}}, c_i[12], c_i[6:2]};
    assign rd_full  = c_i[11:7];
    assign rd_p     = creg(c_i[9:7]);
    assign rs2_p    = creg(c_i[4:2]);
    assign imm_zero = ({c_i[12], c_i[6:2]} == 6'd0);

    function automatic logic [ILEN-1:0] jump_word(input logic [15:2] c,
                                                  input logic [4:0] link);
        return {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3],
                c[12], {8{c[12]}}, link, OPC_JAL};
    endfunction

    function automatic logic [ILEN-1:0] branch_word(input logic [15:2] c,
                                                    input logic ne);
        return {{4{c[12]}}, c[6:5], c[2], 5'd0, creg(c[9:7]),
                {2'b00, ne}, c[11:10], c[4:3], c[12], OPC_BRANCH};
    endfunction

    always_comb begin
        res_o.word    = '0;
        res_o.illegal = 1'b0;
        case (c_i[15:13])
            3'b000: res_o.word = form_i(simm, rd_full, 3'b000, rd_full, OPC_OPIMM);
            3'b001: res_o.word = jump_word(c_i, 5'd1);
            3'b010: res_o.word = form_i(simm, 5'd0, 3'b000, rd_full, OPC_OPIMM);
            3'b011: begin
                if (rd_full == 5'd2)
                    res_o.word = form_i(sp_imm, 5'd2, 3'b000, 5'd2, OPC_OPIMM);
                else
                    res_o.word = {up_imm, rd_full, OPC_LUI};
                res_o.illegal = imm_zero;
            end
            3'b100: begin
                case (c_i[11:10])
                    2'b00: begin
                        res_o.word    = form_i({7'b0000000, c_i[6:2]}, rd_p, 3'b101,
                                               rd_p, OPC_OPIMM);
                        res_o.illegal = c_i[12];
                    end
                    2'b01: begin
                        res_o.word    = form_i({7'b0100000, c_i[6:2]}, rd_p, 3'b101,
                                               rd_p, OPC_OPIMM);
                        res_o.illegal = c_i[12];
                    end
                    2'b10: res_o.word = form_i(simm, rd_p, 3'b111, rd_p, OPC_OPIMM);
                    default: begin
                        if (c_i[12]) begin
                            res_o.illegal = 1'b1;
                        end else begin
                            case (c_i[6:5])
                                2'b00:   res_o.word = form_r(7'b0100000, rs2_p, rd_p,
                                                             3'b000, rd_p);
                                2'b01:   res_o.word = form_r(7'b0, rs2_p, rd_p,
                                                             3'b100, rd_p);
                                2'b10:   res_o.word = form_r(7'b0, rs2_p, rd_p,
                                                             3'b110, rd_p);
                                default: res_o.word = form_r(7'b0, rs2_p, rd_p,
                                                             3'b111, rd_p);
                            endcase
                        end
                    end
                endcase
            end
            3'b101: res_o.word = jump_word(c_i, 5'd0);
            3'b110: res_o.word = branch_word(c_i, 1'b0);
            default: res_o.word = branch_word(c_i, 1'b1);
        endcase
    end

    // R7
    always_comb begin
        if (c_i[15:13] == 3'b100 && !c_i[11] && c_i[12])
            shift_high_bit_chk: assert (res_o.illegal)
                else $error("shift amount bit 5 not flagged");
    end

    // R6
    always_comb begin
        if (c_i[15:13] == 3'b011 && c_i[12] == 1'b0 && c_i[6:2] == 5'd0)
            upper_zero_chk: assert (res_o.illegal)
                else $error("zero upper/stack immediate not flagged");
    end

endmodule

// File: rtl/rvc_exp_q2.sv
module rvc_exp_q2
    import rvc_pkg::*;
(
    input  logic [15:2] c_i,
    output xlat_t       res_o
);

    logic [4:0]  rd_full;
    logic [4:0]  rs2_full;
    logic [11:0] ld_off;
    logic [11:0] st_off;

    assign rd_full  = c_i[11:7];
    assign rs2_full = c_i[6:2];
    assign ld_off   = {4'b0000, c_i[3:2], c_i[12], c_i[6:4], 2'b00};
    assign st_off   = {4'b0000, c_i[8:7], c_i[12:9], 2'b00};

    always_comb begin
        res_o.word    = '0;
        res_o.illegal = 1'b0;
        case (c_i[15:13])
            3'b000: begin
                res_o.word    = form_i({7'b0, rs2_full}, rd_full, 3'b001, rd_full,
                                       OPC_OPIMM);
                res_o.illegal = c_i[12];
            end
            3'b010: begin
                res_o.word    = form_i(ld_off, 5'd2, 3'b010, rd_full, OPC_LOAD);
                res_o.illegal = (rd_full == 5'd0);
            end
            3'b100: begin
                // second source decides first, destination second
                if (rs2_full != 5'd0) begin
                    res_o.word = form_r(7'b0, rs2_full, c_i[12] ? rd_full : 5'd0,
                                        3'b000, rd_full);
                end else if (!c_i[12]) begin
                    res_o.word    = form_i(12'd0, rd_full, 3'b000, 5'd0, OPC_JALR);
                    res_o.illegal = (rd_full == 5'd0);
                end else if (rd_full == 5'd0) begin
                    res_o.word = BREAK_WORD;
                end else begin
                    res_o.word = form_i(12'd0, rd_full, 3'b000, 5'd1, OPC_JALR);
                end
            end
            3'b110: res_o.word = form_s(st_off, rs2_full, 5'd2);
            default: res_o.illegal = 1'b1;
        endcase
    end

    // R10
    always_comb begin
        if (c_i[15:12] == 4'b1000 && c_i[11:2] == 10'd0)
            jr_x0_chk: assert (res_o.illegal)
                else $error("jump through x0 not flagged");
    end

    // R11
    always_comb begin
        if (c_i[15:12] == 4'b1001 && c_i[11:2] == 10'd0)
            break_map_chk: assert (!res_o.illegal && res_o.word == BREAK_WORD)
                else $error("breakpoint mapped wrongly");
    end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
    import rvc_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output logic [ILEN-1:0] instr_o,
    output logic            is_compressed_o,
    output logic            illegal_o
);

    quad_e quad;
    xlat_t res_q0;
    xlat_t res_q1;
    xlat_t res_q2;
    xlat_t picked;

    assign quad = quad_e'(instr_i[1:0]);

    rvc_exp_q0 u_q0 (.c_i(instr_i[CLEN-1:2]), .res_o(res_q0));
    rvc_exp_q1 u_q1 (.c_i(instr_i[CLEN-1:2]), .res_o(res_q1));
    rvc_exp_q2 u_q2 (.c_i(instr_i[CLEN-1:2]), .res_o(res_q2));

    always_comb begin
        case (quad)
            QUAD0:   picked = res_q0;
            QUAD1:   picked = res_q1;
            QUAD2:   picked = res_q2;
            default: picked = '{word: instr_i, illegal: 1'b0};
        endcase
    end

    always_comb begin
        is_compressed_o = (quad != QUAD_FULL);
        illegal_o       = is_compressed_o && picked.illegal;
        instr_o         = illegal_o ? instr_i : picked.word;
    end

    // R1
    always_comb begin
        if (instr_i[1:0] == 2'b11)
            passthru_chk: assert (instr_o == instr_i && !is_compressed_o && !illegal_o)
                else $error("full-width word altered");
    end

    // R2
    always_comb begin
        if (illegal_o)
            illegal_raw_chk: assert (instr_o == instr_i && is_compressed_o)
                else $error("illegal output is not the raw word");
    end

    // R2
    always_comb begin
        if (is_compressed_o && !illegal_o)
            expand_width_chk: assert (instr_o[1:0] == 2'b11)
                else $error("expansion lacks full-width opcode bits");
    end

endmodule

// File: tb/tb_rvc_expander.sv
module tb_rvc_expander;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] instr_o;
    logic        is_compressed_o;
    logic        illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvc_expander dut (
        .instr_i(instr_i),
        .instr_o(instr_o),
        .is_compressed_o(is_compressed_o),
        .illegal_o(illegal_o)
    );

    // base-format encoders used to build expected words
    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'h33};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3);
        return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
    endfunction
    function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd);
        return {imm, rd, 7'h37};
    endfunction
    function automatic logic [31:0] h(input logic [15:0] c);
        return {16'h0000, c};
    endfunction

    typedef struct packed {
        logic [31:0] din;
        logic [31:0] dout;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 53;
    localparam vec_t VEC [NV] = '{
        // R1 full-width words
        '{32'h00a5_0533, 32'h00a5_0533, 1'b0, 4'd1},
        '{32'hffff_ffff, 32'hffff_ffff, 1'b0, 4'd1},
        // R3 quadrant 0
        '{h(16'h0000), 32'h0, 1'b1, 4'd3},
        '{h({3'b000, 2'b01, 4'b0000, 1'b0, 1'b0, 3'b001, 2'b00}), enc_i(12'd16, 5'd2, 3'd0, 5'd9, 7'h13), 1'b0, 4'd3},
        '{h({3'b000, 8'h00, 3'b001, 2'b00}), 32'h0, 1'b1, 4'd3},
        '{h({3'b010, 3'b000, 3'b011, 1'b1, 1'b0, 3'b010, 2'b00}), enc_i(12'd4, 5'd11, 3'd2, 5'd10, 7'h03), 1'b0, 4'd3},
        '{h({3'b110, 3'b000, 3'b101, 1'b0, 1'b1, 3'b100, 2'b00}), enc_s(12'd64, 5'd12, 5'd13), 1'b0, 4'd3},
        // R4 unsupported slots
        '{h({3'b001, 8'hA5, 3'b010, 2'b00}), 32'h0, 1'b1, 4'd4},
        '{h({3'b100, 8'h0F, 3'b001, 2'b00}), 32'h0, 1'b1, 4'd4},
        '{h({3'b111, 8'h33, 3'b000, 2'b00}), 32'h0, 1'b1, 4'd4},
        '{h({3'b101, 11'h155, 2'b10}), 32'h0, 1'b1, 4'd4},
        '{h({3'b011, 11'h02A, 2'b10}), 32'h0, 1'b1, 4'd4},
        // R5 immediates and jumps
        '{h({3'b000, 1'b1, 5'd5, 5'b11101, 2'b01}), enc_i(12'hFFD, 5'd5, 3'd0, 5'd5, 7'h13), 1'b0, 4'd5},
        '{h(16'h0001), 32'h0000_0013, 1'b0, 4'd5},
        '{h({3'b010, 1'b0, 5'd7, 5'd7, 2'b01}), enc_i(12'd7, 5'd0, 3'd0, 5'd7, 7'h13), 1'b0, 4'd5},
        '{h({3'b010, 1'b0, 5'd0, 5'd5, 2'b01}), enc_i(12'd5, 5'd0, 3'd0, 5'd0, 7'h13), 1'b0, 4'd5},
        '{h({3'b001, 11'h7FF, 2'b01}), enc_j(21'h1FFFFE, 5'd1), 1'b0, 4'd5},
        '{h({3'b101, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 2'b01}), enc_j(21'd256, 5'd0), 1'b0, 4'd5},
        // R6 upper immediate and stack adjust
        '{h({3'b011, 1'b0, 5'd3, 5'd1, 2'b01}), enc_u(20'h00001, 5'd3), 1'b0, 4'd6},
        '{h({3'b011, 1'b1, 5'd3, 5'd0, 2'b01}), enc_u(20'hFFFE0, 5'd3), 1'b0, 4'd6},
        '{h({3'b011, 1'b0, 5'd3, 5'd0, 2'b01}), 32'h0, 1'b1, 4'd6},
        '{h({3'b011, 1'b0, 5'd2, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01}), enc_i(12'd16, 5'd2, 3'd0, 5'd2, 7'h13), 1'b0, 4'd6},
        '{h({3'b011, 1'b1, 5'd2, 5'd0, 2'b01}), enc_i(12'hE00, 5'd2, 3'd0, 5'd2, 7'h13), 1'b0, 4'd6},
        '{h({3'b011, 1'b0, 5'd2, 5'd0, 2'b01}), 32'h0, 1'b1, 4'd6},
        '{h({3'b011, 1'b0, 5'd0, 5'd1, 2'b01}), enc_u(20'h00001, 5'd0), 1'b0, 4'd6},
        // R7 shifts
        '{h({3'b100, 1'b0, 2'b00, 3'b000, 5'd3, 2'b01}), enc_i(12'd3, 5'd8, 3'd5, 5'd8, 7'h13), 1'b0, 4'd7},
        '{h({3'b100, 1'b0, 2'b01, 3'b111, 5'd31, 2'b01}), enc_i({7'h20, 5'd31}, 5'd15, 3'd5, 5'd15, 7'h13), 1'b0, 4'd7},
        '{h({3'b100, 1'b1, 2'b00, 3'b000, 5'd1, 2'b01}), 32'h0, 1'b1, 4'd7},
        '{h({3'b000, 1'b0, 5'd1, 5'd1, 2'b10}), enc_i(12'd1, 5'd1, 3'd1, 5'd1, 7'h13), 1'b0, 4'd7},
        '{h({3'b000, 1'b1, 5'd1, 5'd0, 2'b10}), 32'h0, 1'b1, 4'd7},
        '{h({3'b100, 1'b0, 2'b00, 3'b001, 5'd0, 2'b01}), enc_i(12'd0, 5'd9, 3'd5, 5'd9, 7'h13), 1'b0, 4'd7},
        '{h({3'b000, 1'b0, 5'd0, 5'd4, 2'b10}), enc_i(12'd4, 5'd0, 3'd1, 5'd0, 7'h13), 1'b0, 4'd7},
        // R8 logic and register-register
        '{h({3'b100, 1'b1, 2'b10, 3'b010, 5'b11111, 2'b01}), enc_i(12'hFFF, 5'd10, 3'd7, 5'd10, 7'h13), 1'b0, 4'd8},
        '{h({3'b100, 1'b0, 2'b11, 3'b000, 2'b00, 3'b001, 2'b01}), enc_r(7'h20, 5'd9, 5'd8, 3'd0, 5'd8), 1'b0, 4'd8},
        '{h({3'b100, 1'b0, 2'b11, 3'b011, 2'b01, 3'b100, 2'b01}), enc_r(7'h00, 5'd12, 5'd11, 3'd4, 5'd11), 1'b0, 4'd8},
        '{h({3'b100, 1'b0, 2'b11, 3'b110, 2'b10, 3'b111, 2'b01}), enc_r(7'h00, 5'd15, 5'd14, 3'd6, 5'd14), 1'b0, 4'd8},
        '{h({3'b100, 1'b0, 2'b11, 3'b000, 2'b11, 3'b000, 2'b01}), enc_r(7'h00, 5'd8, 5'd8, 3'd7, 5'd8), 1'b0, 4'd8},
        '{h({3'b100, 1'b1, 2'b11, 3'b000, 2'b00, 3'b001, 2'b01}), 32'h0, 1'b1, 4'd8},
        // R9 branches
        '{h({3'b110, 1'b0, 2'b01, 3'b000, 2'b00, 2'b00, 1'b0, 2'b01}), enc_b(13'd8, 5'd8, 3'd0), 1'b0, 4'd9},
        '{h({3'b111, 1'b1, 2'b11, 3'b001, 2'b11, 2'b11, 1'b1, 2'b01}), enc_b(13'h1FFE, 5'd9, 3'd1), 1'b0, 4'd9},
        // R10 move / jump-register
        '{h({3'b100, 1'b0, 5'd5, 5'd6, 2'b10}), enc_r(7'h00, 5'd6, 5'd0, 3'd0, 5'd5), 1'b0, 4'd10},
        '{h({3'b100, 1'b0, 5'd0, 5'd6, 2'b10}), enc_r(7'h00, 5'd6, 5'd0, 3'd0, 5'd0), 1'b0, 4'd10},
        '{h({3'b100, 1'b0, 5'd1, 5'd0, 2'b10}), enc_i(12'd0, 5'd1, 3'd0, 5'd0, 7'h67), 1'b0, 4'd10},
        '{h({3'b100, 1'b0, 5'd0, 5'd0, 2'b10}), 32'h0, 1'b1, 4'd10},
        // R11 add / link-jump / breakpoint
        '{h({3'b100, 1'b1, 5'd5, 5'd6, 2'b10}), enc_r(7'h00, 5'd6, 5'd5, 3'd0, 5'd5), 1'b0, 4'd11},
        '{h({3'b100, 1'b1, 5'd0, 5'd6, 2'b10}), enc_r(7'h00, 5'd6, 5'd0, 3'd0, 5'd0), 1'b0, 4'd11},
        '{h({3'b100, 1'b1, 5'd7, 5'd0, 2'b10}), enc_i(12'd0, 5'd7, 3'd0, 5'd1, 7'h67), 1'b0, 4'd11},
        '{h(16'h9002), 32'h0010_0073, 1'b0, 4'd11},
        // R12 stack-relative load/store
        '{h({3'b010, 1'b0, 5'd10, 3'b010, 2'b00, 2'b10}), enc_i(12'd8, 5'd2, 3'd2, 5'd10, 7'h03), 1'b0, 4'd12},
        '{h({3'b010, 1'b1, 5'd1, 5'b11111, 2'b10}), enc_i(12'd252, 5'd2, 3'd2, 5'd1, 7'h03), 1'b0, 4'd12},
        '{h({3'b010, 1'b0, 5'd0, 5'b00100, 2'b10}), 32'h0, 1'b1, 4'd12},
        '{h({3'b110, 4'b0011, 2'b00, 5'd9, 2'b10}), enc_s(12'd12, 5'd9, 5'd2), 1'b0, 4'd12},
        // R2 upper halfword ignored
        '{{16'hDEAD, 3'b000, 1'b1, 5'd5, 5'b11101, 2'b01}, enc_i(12'hFFD, 5'd5, 3'd0, 5'd5, 7'h13), 1'b0, 4'd2}
    };

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr_i = w;
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input string tag, input logic [31:0] exp_w,
                         input logic exp_c, input logic exp_i);
        n_checks++;
        if (instr_o !== exp_w || is_compressed_o !== exp_c || illegal_o !== exp_i) begin
            n_fail++;
            $display("FAIL %s in=%h word=%h exp %h comp=%b exp %b ill=%b exp %b",
                     tag, instr_i, instr_o, exp_w, is_compressed_o, exp_c, illegal_o, exp_i);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, exp completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].din);
            check($sformatf("R%0d vec%0d", VEC[i].req, i),
                  VEC[i].ill ? VEC[i].din : VEC[i].dout,
                  VEC[i].din[1:0] != 2'b11, VEC[i].ill);
        end

        // R2: upper halfword has no effect, legal and illegal cases
        for (int k = 0; k < 8; k++) begin
            logic [15:0] up;
            up = 16'h1357 * k[15:0] + 16'hA5A5;
            apply({up, 3'b100, 1'b1, 5'd5, 5'd6, 2'b10});
            check("R2 upper ignored legal", enc_r(7'h00, 5'd6, 5'd5, 3'd0, 5'd5), 1'b1, 1'b0);
            apply({up, 3'b100, 1'b0, 5'd0, 5'd0, 2'b10});
            check("R2 upper kept on illegal", {up, 16'h8002}, 1'b1, 1'b1);
        end

        // R1: full-width words untouched regardless of contents
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            w = (32'h9E37_79B9 * k) | 32'h3;
            apply(w);
            check("R1 pass-through", w, 1'b0, 1'b0);
        end

        // R10 / R11: rs2 decides before rd/rs1 over every field pair
        for (int b = 0; b < 2; b++) begin
            for (int rd = 0; rd < 32; rd++) begin
                for (int rs = 0; rs < 32; rs++) begin
                    logic [31:0] exp_w;
                    logic        exp_i;
                    logic [31:0] w;
                    w = {16'h0, 3'b100, b[0], rd[4:0], rs[4:0], 2'b10};
                    exp_i = 1'b0;
                    if (rs != 0)
                        exp_w = enc_r(7'h00, rs[4:0], b[0] ? rd[4:0] : 5'd0, 3'd0, rd[4:0]);
                    else if (b == 0) begin
                        exp_i = (rd == 0);
                        exp_w = exp_i ? w : enc_i(12'd0, rd[4:0], 3'd0, 5'd0, 7'h67);
                    end else
                        exp_w = (rd == 0) ? 32'h0010_0073
                                          : enc_i(12'd0, rd[4:0], 3'd0, 5'd1, 7'h67);
                    apply(w);
                    check(b ? "R11 precedence sweep" : "R10 precedence sweep",
                          exp_w, 1'b1, exp_i);
                end
            end
        end

        // R2: every halfword obeys the flag and raw-word rules
        begin
            int bad;
            logic [31:0] first_w;
            logic [31:0] first_o;
            bad = 0;
            first_w = '0;
            first_o = '0;
            for (int v = 0; v < 65536; v++) begin
                logic ok;
                apply({16'h0000, v[15:0]});
                if (v[1:0] == 2'b11)
                    ok = (instr_o == instr_i) && !is_compressed_o && !illegal_o;
                else if (illegal_o)
                    ok = (instr_o == instr_i) && is_compressed_o;
                else
                    ok = (instr_o[1:0] == 2'b11) && is_compressed_o;
                if (!ok) begin
                    if (bad == 0) begin
                        first_w = instr_i;
                        first_o = instr_o;
                    end
                    bad++;
                end
            end
            n_checks++;
            if (bad != 0) begin
                n_fail++;
                $display("FAIL R2 full sweep: %0d bad, first in=%h out=%h exp 0 bad",
                         bad, first_w, first_o);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule